// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a 32-bit byte-addressed processor and a word-wide memory port. It holds a direct-mapped array of lines. Each line keeps a valid flag, a dirty flag, a tag and a block of several 32-bit words. The processor posts one access at a time with a single-cycle request pulse. On a hit, the access finishes on the next cycle. On a miss, the controller raises a stall and writes back the victim line if that line is dirty. It then fetches the whole new block one word per beat and replays the access, which now hits.

An address is cut into four fields: byte offset, block offset, index and tag. The byte offset is ignored. The block offset picks one word of the line through a multiplexer. The index is the block address modulo the line count. The tag is compared with the stored tag. Stores use write-allocate and write-back: a store that misses first loads the whole line and then merges the new word into it. A store that hits touches only the cache and marks the line dirty.

Top module: `dmc_cache`

## Requirements
- R1: The address is split as byte offset [1:0], block offset [OFFS_W+1:2], index [OFFS_W+INDEX_W+1:OFFS_W+2] and tag (remaining upper bits). The byte offset has no effect on which word is accessed, and memory addresses are always word aligned.
- R2: After reset, every line is invalid and clean, `cpu_stall`, `cpu_done` and `mem_req` are low, and the first access to any address is a miss.
- R3: A load whose line is valid with a matching tag raises `cpu_done` exactly one cycle after the request is taken. It never raises `cpu_stall` and produces no memory beat.
- R4: The data returned with `cpu_done` is the word chosen by the block offset, and it reflects every earlier store to that word.
- R5: A load miss fetches all 2^OFFS_W words of the block, with block offsets ascending from 0 at the requested tag and index. Each word is written into the line, and the access then completes as a hit.
- R6: A store miss first refills the whole line from memory and then replaces only the addressed word. The other words of the line hold the memory contents.
- R7: A store hit updates only the cache word, marks the line dirty and produces no memory beat.
- R8: A miss that replaces a valid dirty line first writes its 2^OFFS_W words to memory, in ascending offset order, at the address built from the old tag and the index. The refill starts only after that.
- R9: A miss that replaces a clean or invalid line produces no write beat.
- R10: `cpu_stall` rises on the cycle after a miss is detected and stays high until the cycle in which the replayed access raises `cpu_done`, where it is low. Memory beats occur only while stalled, and `cpu_done` lasts one cycle.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged. A beat completes only on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request pulse, taken when the controller is idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_done` is high |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a miss is being serviced |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, sampled when `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts or delivers the current beat |

## Verification
The properties assume that the memory side behaves as a plain ready-gated slave: `mem_ready` can be held low for any number of cycles, but the memory never returns data for a beat it was not asked for. They also assume that the processor sends a new request only after the previous access has completed. The stimulus follows both rules. It issues each access only after seeing `cpu_done` for the one before. It drives `mem_ready` from a pseudo-random gate that is combined with `mem_req`, so every stretch of back-pressure comes from the bench and is finite. The addresses are confined to a few tag values, so that conflicts, dirty evictions and clean evictions all occur often.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   localparam int WORD_W = 32;
   localparam int BYTE_W = 2;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_COMPARE   = 3'd1,
      ST_WRITEBACK = 3'd2,
      ST_REFILL    = 3'd3,
      ST_RESTART   = 3'd4
   } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int ADDR_W  = 32,
   parameter int INDEX_W = 8,
   parameter int OFFS_W  = 4
) (
   input  logic [ADDR_W-1:0]                            addr,
   output logic [ADDR_W-INDEX_W-OFFS_W-dmc_pkg::BYTE_W-1:0] tag,
   output logic [INDEX_W-1:0]                           idx,
   output logic [OFFS_W-1:0]                            off
);
   localparam int BW    = dmc_pkg::BYTE_W;
   localparam int IDX_LO = BW + OFFS_W;
   localparam int TAG_LO = IDX_LO + INDEX_W;

   assign off = addr[IDX_LO-1:BW];
   assign idx = addr[TAG_LO-1:IDX_LO];
   assign tag = addr[ADDR_W-1:TAG_LO];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int INDEX_W = 8,
   parameter int TAG_W   = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] idx,
   output logic               line_valid,
   output logic               line_dirty,
   output logic [TAG_W-1:0]   line_tag,
   input  logic               fill_en,
   input  logic [TAG_W-1:0]   fill_tag,
   input  logic               mark_dirty
);
   localparam int LINES = 1 << INDEX_W;

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= 1'b0;
      end else if (mark_dirty) begin
         dirty_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[idx] <= fill_tag;
   end

   assign line_valid = valid_q[idx];
   assign line_dirty = dirty_q[idx];
   assign line_tag   = tag_q[idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int INDEX_W = 8,
   parameter int OFFS_W  = 4
) (
   input  logic                       clk,
   input  logic [INDEX_W-1:0]         idx,
   input  logic [OFFS_W-1:0]          word_sel,
   input  logic                       wr_en,
   input  logic [dmc_pkg::WORD_W-1:0] wr_data,
   output logic [dmc_pkg::WORD_W-1:0] rd_data
);
   localparam int LINES = 1 << INDEX_W;
   localparam int WORDS = 1 << OFFS_W;
   localparam int WW    = dmc_pkg::WORD_W;

   logic [WW-1:0] bank_out [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_bank
      logic [WW-1:0] cells [LINES];
      always_ff @(posedge clk) begin
         if (wr_en && (word_sel == OFFS_W'(w))) cells[idx] <= wr_data;
      end
      assign bank_out[w] = cells[idx];
   end

   assign rd_data = bank_out[word_sel];
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
   parameter int ADDR_W  = 32,
   parameter int INDEX_W = 8,
   parameter int OFFS_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   output logic              cpu_done,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ready
);
   import dmc_pkg::*;

   localparam int TAG_W = ADDR_W - INDEX_W - OFFS_W - BYTE_W;
   localparam logic [OFFS_W-1:0] LAST_BEAT = {OFFS_W{1'b1}};

   initial begin
      assert (TAG_W >= 1) else $error("dmc_cache: address too narrow for index and offset");
      assert (OFFS_W >= 1) else $error("dmc_cache: a line needs at least two words");
      assert (INDEX_W >= 1) else $error("dmc_cache: at least two lines required");
   end

   dmc_state_e        state;
   logic [ADDR_W-1:0] req_addr;
   logic              req_we;
   logic [31:0]       req_wdata;
   logic [OFFS_W-1:0] beat;

   logic [TAG_W-1:0]   req_tag;
   logic [INDEX_W-1:0] req_idx;
   logic [OFFS_W-1:0]  req_off;

   dmc_addr_split #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .OFFS_W(OFFS_W)) u_split (
      .addr (req_addr),
      .tag  (req_tag),
      .idx  (req_idx),
      .off  (req_off)
   );

   logic             line_valid, line_dirty;
   logic [TAG_W-1:0] line_tag;
   logic             hit;
   logic             beat_done;
   logic             fill_en, mark_dirty;

   assign hit        = (state == ST_COMPARE) && line_valid && (line_tag == req_tag);
   assign beat_done  = mem_req && mem_ready;
   assign fill_en    = (state == ST_REFILL) && mem_ready && (beat == LAST_BEAT);
   assign mark_dirty = hit && req_we;

   dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (req_idx),
      .line_valid (line_valid),
      .line_dirty (line_dirty),
      .line_tag   (line_tag),
      .fill_en    (fill_en),
      .fill_tag   (req_tag),
      .mark_dirty (mark_dirty)
   );

   logic              data_we;
   logic [OFFS_W-1:0] data_sel;
   logic [31:0]       data_in, data_out;

   always_comb begin
      data_we  = 1'b0;
      data_sel = req_off;
      data_in  = req_wdata;
      case (state)
         ST_WRITEBACK: data_sel = beat;
         ST_REFILL: begin
            data_sel = beat;
            data_in  = mem_rdata;
            data_we  = mem_ready;
         end
         ST_COMPARE: data_we = hit && req_we;
         default: ;
      endcase
   end

   dmc_data_store #(.INDEX_W(INDEX_W), .OFFS_W(OFFS_W)) u_data (
      .clk      (clk),
      .idx      (req_idx),
      .word_sel (data_sel),
      .wr_en    (data_we),
      .wr_data  (data_in),
      .rd_data  (data_out)
   );

   assign mem_req   = (state == ST_WRITEBACK) || (state == ST_REFILL);
   assign mem_we    = (state == ST_WRITEBACK);
   assign mem_wdata = data_out;
   assign mem_addr  = (state == ST_WRITEBACK) ? {line_tag, req_idx, beat, {BYTE_W{1'b0}}}
                                              : {req_tag,  req_idx, beat, {BYTE_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         req_addr  <= '0;
         req_we    <= 1'b0;
         req_wdata <= '0;
         beat      <= '0;
         cpu_done  <= 1'b0;
         cpu_stall <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         cpu_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cpu_req) begin
                  req_addr  <= cpu_addr;
                  req_we    <= cpu_we;
                  req_wdata <= cpu_wdata;
                  state     <= ST_COMPARE;
               end
            end
            ST_COMPARE: begin
               if (hit) begin
                  cpu_done  <= 1'b1;
                  cpu_stall <= 1'b0;
                  if (!req_we) cpu_rdata <= data_out;
                  state <= ST_IDLE;
               end else begin
                  cpu_stall <= 1'b1;
                  beat      <= '0;
                  state     <= (line_valid && line_dirty) ? ST_WRITEBACK : ST_REFILL;
               end
            end
            ST_WRITEBACK: begin
               if (beat_done) begin
                  beat <= beat + 1'b1;
                  if (beat == LAST_BEAT) state <= ST_REFILL;
               end
            end
            ST_REFILL: begin
               if (beat_done) begin
                  beat <= beat + 1'b1;
                  if (beat == LAST_BEAT) state <= ST_RESTART;
               end
            end
            ST_RESTART: state <= ST_COMPARE;
            default:    state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_done,
   input logic              cpu_stall,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_ready
);
   localparam logic [OFFS_W-1:0] LAST = {OFFS_W{1'b1}};

   logic [OFFS_W-1:0] moff;
   assign moff = mem_addr[OFFS_W+1:2];

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

   p_beat_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && (moff != LAST)) |=>
      (mem_req && (mem_we == $past(mem_we)) && (moff == $past(moff) + 1'b1)));

   p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   p_mem_in_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_stall);

   p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_stall);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);
endmodule

bind dmc_cache dmc_cache_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_done  (cpu_done),
   .cpu_stall (cpu_stall),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready)
);

// File: tb/dmc_cache_test.sv
module dmc_cache_test;
   // small configuration: 4 lines of 4 words; bench addresses use tag values 0..3
   localparam int IW = 2;
   localparam int OW = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_done, cpu_stall;
   logic        mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #10 clk = ~clk;

   dmc_cache #(.ADDR_W(32), .INDEX_W(IW), .OFFS_W(OW)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // memory model
   logic [31:0] tbmem [64];
   logic [31:0] refm  [64];
   logic        gate = 1'b0;
   logic [15:0] glfsr = 16'h5a3c;
   logic [1:0]  cur_tag, cur_idx, old_tag;
   int          rd_total = 0, wr_total = 0, bad_total = 0;

   assign mem_ready = mem_req && gate;
   assign mem_rdata = tbmem[mem_addr[7:2]];

   always @(negedge clk) begin
      glfsr = {glfsr[14:0], glfsr[15] ^ glfsr[13] ^ glfsr[12] ^ glfsr[10]};
      gate  = glfsr[0] | glfsr[3];
   end

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         if (mem_we) begin
            if (mem_addr[31:2] != {24'h0, old_tag, cur_idx, wr_total[1:0]}) bad_total++;
            tbmem[mem_addr[7:2]] <= mem_wdata;
            wr_total++;
         end else begin
            if (mem_addr[31:2] != {24'h0, cur_tag, cur_idx, rd_total[1:0]}) bad_total++;
            rd_total++;
         end
      end
   end

   int checks = 0, fails = 0;
   logic [1:0] btag [4];
   logic [3:0] bvalid = '0, bdirty = '0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   task automatic access(input logic we, input logic [7:0] a, input logic [31:0] wd);
      logic [1:0] ix, tg;
      logic [5:0] wi;
      bit exp_hit, exp_wb, saw;
      int n, rd0, wr0, bad0;
      ix = a[5:4]; tg = a[7:6]; wi = a[7:2];
      exp_hit = bvalid[ix] && (btag[ix] == tg);
      exp_wb  = !exp_hit && bvalid[ix] && bdirty[ix];
      cur_tag = tg; cur_idx = ix; old_tag = btag[ix];
      rd0 = rd_total; wr0 = wr_total; bad0 = bad_total;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = {24'h0, a}; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      n = 0; saw = 0;
      while (!cpu_done) begin
         if (cpu_stall) saw = 1;
         @(negedge clk);
         n++;
      end
      if (exp_hit) begin
         // R3 (load hit) / R7 (store hit): one cycle, no stall, no memory beat
         check(n == 1 && !saw && rd_total == rd0 && wr_total == wr0,
               we ? "R7 store hit timing/traffic" : "R3 load hit timing/traffic", n, 1);
      end else begin
         // R5/R6 refill of 4 beats, R8/R9 write-back present or absent, R10 stall
         check(saw && (rd_total - rd0) == 4, we ? "R6 store miss refill" : "R5 load miss refill",
               rd_total - rd0, 4);
         check((wr_total - wr0) == (exp_wb ? 4 : 0), exp_wb ? "R8 dirty write-back" : "R9 clean no write-back",
               wr_total - wr0, exp_wb ? 4 : 0);
         check(bad_total == bad0, "R8 R5 R1 beat address order", bad_total - bad0, 0);
      end
      check(!cpu_stall, "R10 stall low at done", cpu_stall, 0);
      if (!we) check(cpu_rdata == refm[wi], "R4 R1 load data", cpu_rdata, refm[wi]);
      if (we) refm[wi] = wd;
      if (!exp_hit) begin
         bvalid[ix] = 1'b1; btag[ix] = tg; bdirty[ix] = we;
      end else if (we) bdirty[ix] = 1'b1;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
         summary();
      end
   end

   initial begin
      logic [15:0] lf;
      for (int i = 0; i < 64; i++) begin
         tbmem[i] = (32'h0101_0001 * (i + 1)) ^ 32'hC3C3_0000;
         refm[i]  = tbmem[i];
      end
      for (int i = 0; i < 4; i++) btag[i] = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: idle outputs after reset
      check(!cpu_stall && !cpu_done && !mem_req, "R2 reset state", {cpu_stall, cpu_done, mem_req}, 0);
      // directed corner cases
      access(1'b0, 8'h00, 0);            // R2 first access misses, clean refill
      access(1'b0, 8'h04, 0);            // R3 hit, other word
      access(1'b0, 8'h0B, 0);            // R1 byte offset ignored
      access(1'b1, 8'h10, 32'hDEAD_BEEF); // R6 store miss
      access(1'b0, 8'h14, 0);            // R6 neighbour word from memory
      access(1'b0, 8'h10, 0);            // R6 merged word
      access(1'b1, 8'h00, 32'h1234_5678); // R7 store hit
      access(1'b0, 8'h40, 0);            // R8 dirty eviction
      access(1'b0, 8'h00, 0);            // R9 clean eviction, written-back data
      // exhaustive load sweep over all words, varying byte offset
      for (int w = 0; w < 64; w++) access(1'b0, {w[5:0], w[1:0] ^ w[3:2]}, 0);
      // pseudo-random mixed sweep
      lf = 16'hACE1;
      for (int k = 0; k < 700; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         access(lf[8] & lf[11], lf[7:0], {lf, ~lf});
      end
      // R8: memory holds the latest data for every word not held dirty in the cache
      for (int w = 0; w < 64; w++) begin
         if (!(bvalid[w[3:2]] && bdirty[w[3:2]] && btag[w[3:2]] == w[5:4]))
            check(tbmem[w] == refm[w], "R8 memory coherence after write-back", tbmem[w], refm[w]);
      end
      summary();
   end
endmodule